// File: doc/BRIEF.md
# Register bank to stream bridge

This block is a bus slave placed between a processor's memory-mapped master port and a hardware accelerator. It holds a bank of `NUM_REGS` data registers, with up to 32 registers and a width of `DATA_W` (32, 64 or 128 bits). A direction mask that software can rewrite at any time marks each register as outbound (toward the accelerator) or inbound (from the accelerator).

Software starts a transfer through a go bit. The block then streams every outbound register to the accelerator as one packet. Each beat carries the register index, and the last beat is flagged. Inbound beats from the accelerator carry their own index and are written into the matching register. The processor and the accelerator may hit the same register in the same cycle. In that case the processor's write lands first and the accelerator's value follows one cycle later.

A small interrupt section handles the accelerator's event lines. It latches each event into a sticky status bit and gates the status with a per-event enable to drive one processor interrupt line.

Top module: `rsb_bridge`

## Requirements
- R1: After reset, every data register reads 0. The direction mask is 0, so all registers are outbound. Interrupt status and enables are 0, `irq` is low, `txValid` is low and the busy bit reads 0.
- R2: A write with `busAddr` below `NUM_REGS` stores `busWrData` in that register. A read returns the addressed value on `busRdData` with `busRdAck` high one cycle after `busRdValid`.
- R3: Address 32 holds the direction mask, which is readable and writable. Bit i = 1 makes register i inbound and bit i = 0 makes it outbound.
- R4: Writing 1 to bit 0 of address 33 while idle starts a packet. Bit 0 of address 33 reads 1 while the packet is in flight. The packet sends every outbound register, using the mask in force at the start, in ascending index order on `txIdx`/`txData`. Inbound registers are skipped. `txLast` is high only on the final beat. If no register is outbound, no beat is sent.
- R5: While `txValid` is high and `txReady` is low, `txValid` stays high and `txIdx` holds.
- R6: An accepted inbound beat (`rxValid` and `rxReady`) whose `rxIdx` names an inbound register stores `rxData` there.
- R7: An accepted inbound beat whose `rxIdx` names an outbound register, or an index not below `NUM_REGS`, changes no register.
- R8: A processor write and an accepted inbound beat may target the same register in one cycle. The register first takes the processor's data, and in the following cycle it takes the accelerator's data. `rxReady` is low in the cycle between.
- R9: Address 34 holds sticky interrupt status. Bit k is set by `evtIn[k]` being high at a clock edge. Writing 1 to a bit clears it, unless its event is high in the same cycle, in which case the bit stays set.
- R10: Address 35 holds the per-event enables. `irq` is high exactly when some status bit and its enable are both 1.
- R11: A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Word address of the bus access |
| busWrValid | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdValid | input | 1 | Read strobe |
| busRdData | output | DATA_W | Read data, one cycle after the strobe |
| busRdAck | output | 1 | Marks valid read data |
| txValid | output | 1 | Outbound beat valid |
| txReady | input | 1 | Accelerator accepts outbound beat |
| txData | output | DATA_W | Outbound register value |
| txIdx | output | 5 | Register index of outbound beat |
| txLast | output | 1 | Final beat of the packet |
| rxValid | input | 1 | Inbound beat valid |
| rxReady | output | 1 | Block accepts inbound beat |
| rxData | input | DATA_W | Inbound register value |
| rxIdx | input | 5 | Target register of inbound beat |
| evtIn | input | NUM_EVT | Accelerator event lines |
| irq | output | 1 | Processor interrupt |

## Verification
The properties assume that the accelerator sees `txValid` before it raises `txReady`, and that it never drives `rxValid` into a register it does not own. The bench holds the event lines low whenever it writes the enables, because the interrupt property is only promised when enables are not being rewritten in that cycle. All stimulus changes on the falling edge and is held for a whole cycle. Collisions are produced on purpose only with an inbound register and a single beat, so `rxReady` is never expected to stay low for more than one cycle.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int ADDR_W = 6;
  localparam int IDX_W = 5;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 6'd32;
  localparam logic [ADDR_W-1:0] ADDR_GO = 6'd33;
  localparam logic [ADDR_W-1:0] ADDR_IST = 6'd34;
  localparam logic [ADDR_W-1:0] ADDR_IEN = 6'd35;

  typedef struct packed {
    logic             cpuWr;
    logic [IDX_W-1:0] cpuIdx;
    logic             accWr;
    logic [IDX_W-1:0] accIdx;
    logic             pendLoad;
    logic             pendApply;
    logic [IDX_W-1:0] pendIdx;
    logic             dirWr;
    logic             stClr;
    logic             enWr;
    logic             rdEn;
  } strobes_t;
endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl import rsb_pkg::*; #(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrValid,
  input  logic              busRdValid,
  input  logic              goBit,
  input  logic [NUM_REGS-1:0] dirMask,
  input  logic              rxValid,
  input  logic [IDX_W-1:0]  rxIdx,
  input  logic              txReady,
  output strobes_t          strb,
  output logic              txValid,
  output logic [IDX_W-1:0]  txIdx,
  output logic              txLast,
  output logic              rxReady,
  output logic              busy
);
  typedef enum logic {IDLE, SEND} txState_t;
  txState_t txState;
  logic [NUM_REGS-1:0] dirSnap;
  logic [IDX_W-1:0] cur;
  logic pendValid;
  logic [IDX_W-1:0] pendIdx;
  logic [31:0] dirFull, snapFull;
  logic cpuWr, rxTake, collide, start;
  logic [IDX_W-1:0] firstIdx, nextIdx;
  logic firstFound, nextFound;

  always_comb begin
    dirFull = '0;
    dirFull[NUM_REGS-1:0] = dirMask;
    snapFull = '0;
    snapFull[NUM_REGS-1:0] = dirSnap;
  end

  // Search for the lowest outbound register (start) and the next one after cur.
  always_comb begin
    firstFound = 1'b0; firstIdx = '0;
    nextFound = 1'b0;  nextIdx = '0;
    for (int j = NUM_REGS - 1; j >= 0; j--) begin
      if (!dirFull[j]) begin
        firstFound = 1'b1; firstIdx = IDX_W'(j);
      end
      if (!snapFull[j] && IDX_W'(j) > cur) begin
        nextFound = 1'b1; nextIdx = IDX_W'(j);
      end
    end
  end

  assign cpuWr   = busWrValid && ({1'b0, busAddr} < 7'(NUM_REGS));
  assign rxReady = !pendValid;
  assign rxTake  = rxValid && rxReady && ({1'b0, rxIdx} < 6'(NUM_REGS)) && dirFull[rxIdx];
  assign collide = rxTake && cpuWr && (busAddr[IDX_W-1:0] == rxIdx);
  assign start   = busWrValid && (busAddr == ADDR_GO) && goBit && (txState == IDLE) && firstFound;

  always_comb begin
    strb.cpuWr     = cpuWr;
    strb.cpuIdx    = busAddr[IDX_W-1:0];
    strb.accWr     = rxTake && !collide;
    strb.accIdx    = rxIdx;
    strb.pendLoad  = collide;
    strb.pendApply = pendValid && !(cpuWr && busAddr[IDX_W-1:0] == pendIdx);
    strb.pendIdx   = pendIdx;
    strb.dirWr     = busWrValid && (busAddr == ADDR_DIR);
    strb.stClr     = busWrValid && (busAddr == ADDR_IST);
    strb.enWr      = busWrValid && (busAddr == ADDR_IEN);
    strb.rdEn      = busRdValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
    end else if (collide) begin
      pendValid <= 1'b1;
      pendIdx   <= rxIdx;
    end else if (strb.pendApply) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= IDLE;
      cur     <= '0;
      dirSnap <= '0;
    end else begin
      case (txState)
        IDLE: if (start) begin
          txState <= SEND;
          cur     <= firstIdx;
          dirSnap <= dirMask;
        end
        SEND: if (txReady) begin
          if (!nextFound) txState <= IDLE;
          else cur <= nextIdx;
        end
        default: txState <= IDLE;
      endcase
    end
  end

  assign txValid = (txState == SEND);
  assign txIdx   = cur;
  assign txLast  = (txState == SEND) && !nextFound;
  assign busy    = (txState == SEND);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txIdx));
  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && txLast |=> !txValid);
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && !txLast |=> txValid && (txIdx > $past(txIdx)));
  a_r8_collide_stall: assert property (@(posedge clk) disable iff (!rstN)
    collide |=> !rxReady);
endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath import rsb_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  parameter int NUM_EVT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] rxData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [IDX_W-1:0]  txIdx,
  input  logic              busy,
  output logic [NUM_REGS-1:0] dirMask,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdAck,
  output logic [DATA_W-1:0] txData,
  output logic              irq
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] pendData, rdMux;
  logic [NUM_EVT-1:0] irqStat, irqEn, clrMask;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) regs[i] <= '0;
      else if (strb.cpuWr && strb.cpuIdx == IDX_W'(i)) regs[i] <= busWrData;
      else if (strb.accWr && strb.accIdx == IDX_W'(i)) regs[i] <= rxData;
      else if (strb.pendApply && strb.pendIdx == IDX_W'(i)) regs[i] <= pendData;
    end
    a_r2_cpu_write: assert property (@(posedge clk) disable iff (!rstN)
      strb.cpuWr && strb.cpuIdx == IDX_W'(i) |=> regs[i] == $past(busWrData));
  end

  assign clrMask = strb.stClr ? busWrData[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendData <= '0;
      dirMask  <= '0;
      irqStat  <= '0;
      irqEn    <= '0;
    end else begin
      if (strb.pendLoad) pendData <= rxData;
      if (strb.dirWr) dirMask <= busWrData[NUM_REGS-1:0];
      if (strb.enWr) irqEn <= busWrData[NUM_EVT-1:0];
      irqStat <= (irqStat & ~clrMask) | evtIn;
    end
  end

  always_comb begin
    txData = '0;
    rdMux  = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (txIdx == IDX_W'(i)) txData = regs[i];
      if (busAddr == ADDR_W'(i)) rdMux = regs[i];
    end
    case (busAddr)
      ADDR_DIR: rdMux = DATA_W'(dirMask);
      ADDR_GO:  rdMux = DATA_W'(busy);
      ADDR_IST: rdMux = DATA_W'(irqStat);
      ADDR_IEN: rdMux = DATA_W'(irqEn);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= '0;
      busRdAck  <= 1'b0;
    end else begin
      busRdAck <= strb.rdEn;
      if (strb.rdEn) busRdData <= rdMux;
    end
  end

  assign irq = |(irqStat & irqEn);

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[k] |=> irqStat[k]);
  end
  a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtIn & irqEn)) && !strb.enWr |=> irq);
endmodule

// File: rtl/rsb_bridge.sv
module rsb_bridge import rsb_pkg::*; #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W = 32,
  parameter int NUM_EVT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrValid,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdValid,
  output logic [DATA_W-1:0] busRdData,
  output logic              busRdAck,
  output logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] txData,
  output logic [IDX_W-1:0]  txIdx,
  output logic              txLast,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [DATA_W-1:0] rxData,
  input  logic [IDX_W-1:0]  rxIdx,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic              irq
);
  strobes_t strb;
  logic [NUM_REGS-1:0] dirMask;
  logic busy;

  rsb_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk, .rstN, .busAddr, .busWrValid, .busRdValid,
    .goBit(busWrData[0]), .dirMask, .rxValid, .rxIdx, .txReady,
    .strb, .txValid, .txIdx, .txLast, .rxReady, .busy
  );

  rsb_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT)) u_dp (
    .clk, .rstN, .strb, .busAddr, .busWrData, .rxData, .evtIn, .txIdx, .busy,
    .dirMask, .busRdData, .busRdAck, .txData, .irq
  );
endmodule

// File: tb/test_rsb_bridge.sv
module test_rsb_bridge;
  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] busAddr = '0;
  logic busWrValid = 1'b0, busRdValid = 1'b0;
  logic [31:0] busWrData = '0, busRdData, txData, rxData = '0;
  logic busRdAck, txValid, txReady = 1'b0, txLast, rxValid = 1'b0, rxReady, irq;
  logic [4:0] txIdx, rxIdx = '0;
  logic [15:0] evtIn = '0;
  int nChecks = 0, nFail = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  rsb_bridge i_rsb_bridge (.*);

  localparam int NV = 6;
  localparam logic [5:0]  VADDR [NV] = '{6'd0, 6'd3, 6'd7, 6'd32, 6'd35, 6'd40};
  localparam logic [31:0] VDATA [NV] = '{32'h11, 32'hDEADBEEF, 32'hFFFFFFFF, 32'h1F52, 32'hFFFF, 32'h1234};
  localparam logic [31:0] VEXP  [NV] = '{32'h11, 32'hDEADBEEF, 32'hFFFFFFFF, 32'h52, 32'hFFFF, 32'h0};

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrValid = 1'b1;
    @(negedge clk);
    busWrValid = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a; busRdValid = 1'b1;
    @(negedge clk);
    busRdValid = 1'b0;
    d = busRdData;
    check("R2 read ack", 64'(busRdAck), 64'd1);
  endtask

  task automatic rxBeat(input logic [4:0] idx, input logic [31:0] d);
    rxIdx = idx; rxData = d; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [4:0] expIdx [5];
    logic [31:0] expDat [5];
    int beats;
    bit seen;
    expIdx = '{5'd0, 5'd2, 5'd3, 5'd5, 5'd7};
    expDat = '{32'h11, 32'h22, 32'hDEADBEEF, 32'h55, 32'hFFFFFFFF};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(6'd0, rd);  check("R1 reg0", 64'(rd), 0);
    busRead(6'd32, rd); check("R1 dir", 64'(rd), 0);
    busRead(6'd35, rd); check("R1 ien", 64'(rd), 0);
    busRead(6'd33, rd); check("R1 busy", 64'(rd), 0);
    check("R1 irq", 64'(irq), 0);
    check("R1 txValid", 64'(txValid), 0);

    // Vector table: R2 data regs, R3 mask, R10 enables, R11 unmapped
    for (int v = 0; v < NV; v++) begin
      busWrite(VADDR[v], VDATA[v]);
      busRead(VADDR[v], rd);
      check("R2/R3/R10/R11 table", 64'(rd), 64'(VEXP[v]));
    end
    busWrite(6'd35, 32'h0);
    busWrite(6'd2, 32'h22);
    busWrite(6'd5, 32'h55);

    // R4/R5 packet with mask 0x52 (inbound 1,4,6)
    busWrite(6'd33, 32'h1);
    check("R4 txValid", 64'(txValid), 1);
    check("R4 first idx", 64'(txIdx), 0);
    busRead(6'd33, rd); check("R4 busy", 64'(rd), 1);
    check("R5 valid held", 64'(txValid), 1);
    check("R5 idx held", 64'(txIdx), 0);
    txReady = 1'b1;
    beats = 0;
    for (int c = 0; c < 12 && beats < 5; c++) begin
      if (txValid) begin
        check("R4 beat idx", 64'(txIdx), 64'(expIdx[beats]));
        check("R4 beat data", 64'(txData), 64'(expDat[beats]));
        check("R4 beat last", 64'(txLast), 64'(beats == 4));
        beats++;
      end
      @(negedge clk);
    end
    check("R4 beat count", 64'(beats), 5);
    check("R4 ends", 64'(txValid), 0);

    // R4 single outbound register
    busWrite(6'd32, 32'hF7);
    busWrite(6'd33, 32'h1);
    check("R4 single idx", 64'(txIdx), 3);
    check("R4 single last", 64'(txLast), 1);
    @(negedge clk);
    check("R4 single ends", 64'(txValid), 0);

    // R4 no outbound register
    busWrite(6'd32, 32'hFF);
    busWrite(6'd33, 32'h1);
    seen = 0;
    for (int c = 0; c < 3; c++) begin
      if (txValid) seen = 1;
      @(negedge clk);
    end
    check("R4 empty packet", 64'(seen), 0);

    // R6/R7 inbound beats
    busWrite(6'd32, 32'h52);
    check("R6 ready", 64'(rxReady), 1);
    rxBeat(5'd4, 32'hA4);
    busRead(6'd4, rd); check("R6 store", 64'(rd), 64'hA4);
    rxBeat(5'd0, 32'hBAD);
    busRead(6'd0, rd); check("R7 outbound ignored", 64'(rd), 64'h11);
    rxBeat(5'd20, 32'hBAD);
    busRead(6'd0, rd); check("R7 out of range", 64'(rd), 64'h11);

    // R8 collision on reg 4
    busAddr = 6'd4; busWrData = 32'hC0FFEE; busWrValid = 1'b1;
    rxIdx = 5'd4; rxData = 32'hACC; rxValid = 1'b1;
    @(negedge clk);
    busWrValid = 1'b0; rxValid = 1'b0;
    check("R8 ready low", 64'(rxReady), 0);
    busRead(6'd4, rd); check("R8 cpu first", 64'(rd), 64'hC0FFEE);
    busRead(6'd4, rd); check("R8 acc next", 64'(rd), 64'hACC);
    check("R8 ready back", 64'(rxReady), 1);

    // R9/R10 interrupts
    busWrite(6'd35, 32'h4);
    evtIn = 16'h24;
    @(negedge clk);
    evtIn = '0;
    check("R10 irq up", 64'(irq), 1);
    busRead(6'd34, rd); check("R9 sticky", 64'(rd), 64'h24);
    busWrite(6'd34, 32'h4);
    busRead(6'd34, rd); check("R9 w1c", 64'(rd), 64'h20);
    check("R10 irq masked", 64'(irq), 0);
    busAddr = 6'd34; busWrData = 32'h20; busWrValid = 1'b1; evtIn = 16'h20;
    @(negedge clk);
    busWrValid = 1'b0; evtIn = '0;
    busRead(6'd34, rd); check("R9 set wins", 64'(rd), 64'h20);
    busWrite(6'd35, 32'h20);
    check("R10 enable pending", 64'(irq), 1);
    busWrite(6'd34, 32'h20);
    busRead(6'd34, rd); check("R9 cleared", 64'(rd), 0);
    check("R10 irq down", 64'(irq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule